// File: doc/BRIEF.md
# Masked Fractional Hamming Distance Matcher

This block decides whether a probe iris code and one stored gallery code come from the same eye. Each code is a long bit vector. It comes with a mask of the same width, and a mask bit marks whether that position can be trusted. For one alignment, the block counts the trusted positions where the two codes differ and the positions that both masks trust. The ratio of the first count to the second is the fractional distance. A smaller ratio means a closer match.

The block compensates for head tilt by rotating the probe code and the probe mask together. The rotation is circular and moves in whole-column steps over a symmetric window of alignments. The block keeps the alignment with the smallest ratio. The gallery sits in an on-chip memory whose words hold a full code and its mask. One word is fetched per request, and every alignment is scored in a single clock cycle. At the end, the best ratio is tested against a 16-bit fractional threshold by cross-multiplication, so no divider is needed. The block then reports the winning counts, the winning alignment and the decision, together with a one-cycle completion strobe.

Top module: `hd_matcher`

## Requirements
- R1: For the alignment it reports, `bestDiff` is the number of positions where the rotated probe code and the gallery code differ and both masks are 1. `bestValid` is the number of positions where both masks are 1.
- R2: Alignment k runs over every integer from -SHIFT_MAX to +SHIFT_MAX. At alignment k, probe code and probe mask are both rotated left by k*COL_BITS bits: bit i moves to bit (i + k*COL_BITS) mod CODE_W, and a negative k rotates right. The gallery word is not rotated. `bestShift` reports k as a signed two's complement value.
- R3: The reported alignment has the smallest ratio diff/valid among alignments with a nonzero valid count. On equal ratios, the lowest k (the one evaluated first) is kept.
- R4: An alignment whose valid count is zero takes no part in the search. If every alignment has a zero valid count, the block reports `bestDiff`=0, `bestValid`=0, `bestShift`=0 and `isMatch`=0.
- R5: `isMatch` is 1 exactly when bestValid is nonzero and bestDiff*65536 < threshold*bestValid. The threshold is an unsigned fraction scaled by 2^16, and equality is not a match.
- R6: `done` is a one-cycle pulse that rises 2*SHIFT_MAX+2 rising clock edges after the edge that accepts `start`. `busy` is 1 from the accepting edge until `done` rises, and it is 0 while `done` is 1.
- R7: A `start` seen while `busy` is 1 is ignored. The reported results stay unchanged from `done` until the next accepted `start`.
- R8: Writing `galWrCode`/`galWrMask` to slot `galWrAddr` on a cycle with `galWrEn`=1 stores them in that slot. A later accepted `start` compares against the slot named by `galSel`. The probe, its mask, the threshold and the slot are all captured on the accepting edge.
- R9: After reset, `busy`, `done` and `isMatch` are 0, and `bestDiff`, `bestValid` and `bestShift` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| galWrEn | input | 1 | Gallery write enable |
| galWrAddr | input | AW | Gallery slot to write |
| galWrCode | input | CODE_W | Code to store |
| galWrMask | input | CODE_W | Mask to store |
| start | input | 1 | Begin a comparison (accepted only when idle) |
| galSel | input | AW | Gallery slot to compare against |
| probeCode | input | CODE_W | Probe code |
| probeMask | input | CODE_W | Probe mask |
| threshold | input | 16 | Match threshold, fraction scaled by 2^16 |
| busy | output | 1 | Comparison in progress |
| done | output | 1 | One-cycle completion strobe |
| isMatch | output | 1 | Match decision |
| bestDiff | output | CNT_W | Disagreement count of the winning alignment |
| bestValid | output | CNT_W | Valid count of the winning alignment |
| bestShift | output | SH_W | Winning alignment k, signed |

## Verification
The assertions check on every cycle the invariants that hold throughout a run. The disagreement count never exceeds the valid count, and a match is never declared without valid positions. The alignment counter stays inside its window, `done` stays a single-cycle pulse, and results stay frozen while no request is running. Only the bench scenarios can show that the rotation direction and the search are right. These scenarios include rotations at both window edges, ties among all alignments, and bands where only one alignment has any overlap. They also cover a threshold that exactly equals the ratio, and requests arriving while the block is busy.

// File: rtl/hd_match_pkg.sv
package hd_match_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadProbe;  // capture probe at the first alignment, clear best
    logic evalCand;   // score current alignment, then step rotation
    logic finish;     // produce decision and done
  } hdCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } hdState_t;

endpackage

// File: rtl/hd_gallery_mem.sv
module hd_gallery_mem #(
  parameter int CODE_W = 2048,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] wrMask,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [CODE_W-1:0] rdCode,
  output logic [CODE_W-1:0] rdMask
);

  logic [2*CODE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= {wrMask, wrCode};
  end

  // Registered read; the word is held until the next read request
  always_ff @(posedge clk) begin
    if (rdEn) {rdMask, rdCode} <= store[rdAddr];
  end

endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
  import hd_match_pkg::*;
#(
  parameter int SHIFT_MAX = 8,
  localparam int SH_W = $clog2(SHIFT_MAX + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output hdCtrl_t                ctrl,
  output logic signed [SH_W-1:0] curShift,
  output logic                   busy
);

  localparam logic signed [SH_W-1:0] SH_LAST  = SH_W'(SHIFT_MAX);
  localparam logic signed [SH_W-1:0] SH_FIRST = -SH_LAST;

  hdState_t state, stateNxt;

  always_comb begin
    stateNxt       = state;
    ctrl           = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.loadProbe = 1'b1;
        stateNxt       = ST_RUN;
      end
      ST_RUN: begin
        ctrl.evalCand = 1'b1;
        if (curShift == SH_LAST) stateNxt = ST_FIN;
      end
      ST_FIN: begin
        ctrl.finish = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curShift <= '0;
    end else begin
      state <= stateNxt;
      if (ctrl.loadProbe)     curShift <= SH_FIRST;
      else if (ctrl.evalCand) curShift <= curShift + SH_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);

  // R2
  shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (curShift >= SH_FIRST && curShift <= SH_LAST));

  // R2
  first_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (curShift == SH_FIRST));

  // R6
  fin_follows_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |-> ($past(state) == ST_RUN && $past(curShift) == SH_LAST));

endmodule

// File: rtl/hd_datapath.sv
module hd_datapath
  import hd_match_pkg::*;
#(
  parameter int CODE_W    = 2048,
  parameter int SHIFT_MAX = 8,
  parameter int COL_BITS  = 8,
  localparam int CNT_W = $clog2(CODE_W + 1),
  localparam int SH_W  = $clog2(SHIFT_MAX + 1) + 1,
  localparam int PRE   = SHIFT_MAX * COL_BITS,
  localparam int PW    = 2 * CNT_W,
  localparam int MW    = CNT_W + 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hdCtrl_t                ctrl,
  input  logic signed [SH_W-1:0] curShift,
  input  logic [CODE_W-1:0]      probeIn,
  input  logic [CODE_W-1:0]      maskIn,
  input  logic [15:0]            thrIn,
  input  logic [CODE_W-1:0]      galCode,
  input  logic [CODE_W-1:0]      galMask,
  output logic [CNT_W-1:0]       bestDiff,
  output logic [CNT_W-1:0]       bestValid,
  output logic signed [SH_W-1:0] bestShift,
  output logic                   isMatch,
  output logic                   done
);

  logic [CODE_W-1:0] probeCode, probeMask;
  logic [15:0]       thrReg;

  function automatic logic [CNT_W-1:0] popCount(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CODE_W; i++) acc += CNT_W'(v[i]);
    return acc;
  endfunction

  logic [CODE_W-1:0] bothMask, disagree;
  logic [CNT_W-1:0]  candDiff, candValid;
  logic [PW-1:0]     candCross, bestCross;
  logic              candBetter;
  logic [MW-1:0]     scaledDiff, thrProd;

  always_comb begin
    bothMask   = probeMask & galMask;
    disagree   = (probeCode ^ galCode) & bothMask;
    candDiff   = popCount(disagree);
    candValid  = popCount(bothMask);
    candCross  = PW'(candDiff) * PW'(bestValid);
    bestCross  = PW'(bestDiff) * PW'(candValid);
    candBetter = (candValid != '0) && ((bestValid == '0) || (candCross < bestCross));
    scaledDiff = {bestDiff, 16'h0000};
    thrProd    = MW'(thrReg) * MW'(bestValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      probeCode <= '0;
      probeMask <= '0;
      thrReg    <= '0;
      bestDiff  <= '0;
      bestValid <= '0;
      bestShift <= '0;
      isMatch   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.loadProbe) begin
        // Pre-rotate to the most negative alignment
        probeCode <= {probeIn[PRE-1:0], probeIn[CODE_W-1:PRE]};
        probeMask <= {maskIn[PRE-1:0], maskIn[CODE_W-1:PRE]};
        thrReg    <= thrIn;
        bestDiff  <= '0;
        bestValid <= '0;
        bestShift <= '0;
        isMatch   <= 1'b0;
      end else if (ctrl.evalCand) begin
        probeCode <= {probeCode[CODE_W-COL_BITS-1:0], probeCode[CODE_W-1:CODE_W-COL_BITS]};
        probeMask <= {probeMask[CODE_W-COL_BITS-1:0], probeMask[CODE_W-1:CODE_W-COL_BITS]};
        if (candBetter) begin
          bestDiff  <= candDiff;
          bestValid <= candValid;
          bestShift <= curShift;
        end
      end else if (ctrl.finish) begin
        isMatch <= (bestValid != '0) && (scaledDiff < thrProd);
      end
    end
  end

  // R1
  diff_within_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    bestDiff <= bestValid);

  // R4
  zero_valid_nomatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bestValid == '0) |-> (!isMatch && bestDiff == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  results_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadProbe && !ctrl.evalCand && !ctrl.finish) |=>
      ($stable(bestDiff) && $stable(bestValid) && $stable(bestShift) && $stable(isMatch)));

endmodule

// File: rtl/hd_matcher.sv
module hd_matcher
  import hd_match_pkg::*;
#(
  parameter int CODE_W    = 2048,
  parameter int SHIFT_MAX = 8,
  parameter int COL_BITS  = 8,
  parameter int DEPTH     = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(CODE_W + 1),
  localparam int SH_W  = $clog2(SHIFT_MAX + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   galWrEn,
  input  logic [AW-1:0]          galWrAddr,
  input  logic [CODE_W-1:0]      galWrCode,
  input  logic [CODE_W-1:0]      galWrMask,
  input  logic                   start,
  input  logic [AW-1:0]          galSel,
  input  logic [CODE_W-1:0]      probeCode,
  input  logic [CODE_W-1:0]      probeMask,
  input  logic [15:0]            threshold,
  output logic                   busy,
  output logic                   done,
  output logic                   isMatch,
  output logic [CNT_W-1:0]       bestDiff,
  output logic [CNT_W-1:0]       bestValid,
  output logic signed [SH_W-1:0] bestShift
);

  hdCtrl_t                ctrl;
  logic signed [SH_W-1:0] curShift;
  logic [CODE_W-1:0]      galCode, galMask;

  hd_gallery_mem #(.CODE_W(CODE_W), .DEPTH(DEPTH)) uMem (
    .clk    (clk),
    .wrEn   (galWrEn),
    .wrAddr (galWrAddr),
    .wrCode (galWrCode),
    .wrMask (galWrMask),
    .rdEn   (ctrl.loadProbe),
    .rdAddr (galSel),
    .rdCode (galCode),
    .rdMask (galMask)
  );

  hd_ctrl #(.SHIFT_MAX(SHIFT_MAX)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ctrl     (ctrl),
    .curShift (curShift),
    .busy     (busy)
  );

  hd_datapath #(.CODE_W(CODE_W), .SHIFT_MAX(SHIFT_MAX), .COL_BITS(COL_BITS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .curShift  (curShift),
    .probeIn   (probeCode),
    .maskIn    (probeMask),
    .thrIn     (threshold),
    .galCode   (galCode),
    .galMask   (galMask),
    .bestDiff  (bestDiff),
    .bestValid (bestValid),
    .bestShift (bestShift),
    .isMatch   (isMatch),
    .done      (done)
  );

endmodule

// File: tb/hd_matcher_test.sv
`timescale 1ns/1ps
module hd_matcher_test;

  localparam int W     = 2048;
  localparam int S     = 8;
  localparam int COL   = 8;
  localparam int DEPTH = 4;
  localparam int AW    = 2;
  localparam int CNT_W = $clog2(W + 1);
  localparam int SH_W  = $clog2(S + 1) + 1;
  localparam int NCOL  = W / COL;
  localparam int LAT   = 2 * S + 2;
  localparam int NVEC  = 11;

  // kind[31:28] rot[27:20] seed[19:16] threshold[15:0]
  // kinds: 0 rotated copy with sparse flips, 1 unrelated, 2 probe mask empty,
  //        3 single overlapping column, 4 identical, 5 all-zero codes (ties)
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0, 8'sd3,  4'd1, 16'h4000},
    {4'd0, -8'sd5, 4'd2, 16'h4000},
    {4'd0, 8'sd8,  4'd3, 16'h4000},
    {4'd0, -8'sd8, 4'd4, 16'h4000},
    {4'd1, 8'sd0,  4'd5, 16'h6000},
    {4'd4, 8'sd0,  4'd6, 16'h0000},
    {4'd4, 8'sd0,  4'd7, 16'h0001},
    {4'd3, 8'sd2,  4'd8, 16'h4000},
    {4'd3, -8'sd6, 4'd9, 16'h4001},
    {4'd5, 8'sd0,  4'd10, 16'h0001},
    {4'd2, 8'sd0,  4'd11, 16'hFFFF}
  };

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   galWrEn = 1'b0;
  logic [AW-1:0]          galWrAddr = '0;
  logic [W-1:0]           galWrCode = '0, galWrMask = '0;
  logic                   start = 1'b0;
  logic [AW-1:0]          galSel = '0;
  logic [W-1:0]           probeCode = '0, probeMask = '0;
  logic [15:0]            threshold = '0;
  logic                   busy, done, isMatch;
  logic [CNT_W-1:0]       bestDiff, bestValid;
  logic signed [SH_W-1:0] bestShift;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hd_matcher #(.CODE_W(W), .SHIFT_MAX(S), .COL_BITS(COL), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .galWrEn(galWrEn), .galWrAddr(galWrAddr),
    .galWrCode(galWrCode), .galWrMask(galWrMask), .start(start), .galSel(galSel),
    .probeCode(probeCode), .probeMask(probeMask), .threshold(threshold),
    .busy(busy), .done(done), .isMatch(isMatch), .bestDiff(bestDiff),
    .bestValid(bestValid), .bestShift(bestShift)
  );

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd(input int unsigned seed);
    logic [W-1:0] r;
    int unsigned st;
    st = seed * 32'h9E3779B9 + 32'h1234567;
    for (int i = 0; i < W / 32; i++) begin
      st ^= st << 13; st ^= st >> 17; st ^= st << 5;
      r[i*32 +: 32] = st;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    int m;
    m = ((n % W) + W) % W;
    if (m == 0) return x;
    return (x << m) | (x >> (W - m));
  endfunction

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  // Reference search per R1..R5
  logic [W-1:0] eP, ePm, eG, eGm;
  int eDiff, eValid, eShift;
  bit eMatch;

  task automatic model(input int thr);
    logic [W-1:0] both;
    int d, v;
    eDiff = 0; eValid = 0; eShift = 0;
    for (int k = -S; k <= S; k++) begin
      both = rotl(ePm, k * COL) & eGm;
      d = ones((rotl(eP, k * COL) ^ eG) & both);
      v = ones(both);
      if (v != 0 && (eValid == 0 || longint'(d) * eValid < longint'(eDiff) * v)) begin
        eDiff = d; eValid = v; eShift = k;
      end
    end
    eMatch = (eValid != 0) && ((longint'(eDiff) << 16) < longint'(thr) * eValid);
  endtask

  task automatic writeSlot(input int slot, input logic [W-1:0] c, input logic [W-1:0] m);
    @(negedge clk);
    galWrEn = 1'b1; galWrAddr = AW'(slot); galWrCode = c; galWrMask = m;
    @(negedge clk);
    galWrEn = 1'b0;
  endtask

  // Pulse start, return number of edges until done; optional intruding start mid-run
  task automatic launch(input int slot, input int thr, input bit intrude, output int lat);
    @(negedge clk);
    probeCode = eP; probeMask = ePm; galSel = AW'(slot); threshold = 16'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (lat < 1000) begin
      if (intrude && lat == 4) begin
        start = 1'b1; probeCode = ~eP; probeMask = '1; threshold = 16'hFFFF;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
  endtask

  task automatic checkResult(input string tag);
    check("R1", {tag, " diff"},  longint'(bestDiff), eDiff);
    check("R1", {tag, " valid"}, longint'(bestValid), eValid);
    check("R3", {tag, " shift"}, longint'(bestShift), eShift);
    check("R5", {tag, " match"}, longint'(isMatch), longint'(eMatch));
  endtask

  task automatic buildVec(input logic [31:0] vec);
    int kind, rot, seed, c0, cg;
    kind = int'(vec[31:28]);
    rot  = int'($signed(vec[27:20]));
    seed = int'(vec[19:16]);
    eP  = rnd(seed * 4 + 1);
    ePm = rnd(seed * 4 + 2) | rnd(seed * 4 + 3);
    eGm = rnd(seed * 4 + 4) | rnd(seed * 4 + 5);
    case (kind)
      0: eG = rotl(eP, rot * COL) ^ (rnd(seed + 40) & rnd(seed + 41) & rnd(seed + 42));
      1: eG = rnd(seed * 4 + 77);
      2: begin eG = eP; ePm = '0; end
      3: begin
        c0  = (seed * 7) % NCOL;
        cg  = (((c0 + rot) % NCOL) + NCOL) % NCOL;
        ePm = '0; eGm = '0;
        ePm[c0*COL +: COL] = '1;
        eGm[cg*COL +: COL] = '1;
        eG = rotl(eP, rot * COL);
        eG[cg*COL +: 2] = ~eG[cg*COL +: 2];
      end
      4: eG = eP;
      default: begin eP = '0; eG = '0; ePm = '1; eGm = '1; end
    endcase
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "busy", longint'(busy), 0);
    check("R9", "done", longint'(done), 0);
    check("R9", "isMatch", longint'(isMatch), 0);
    check("R9", "bestDiff", longint'(bestDiff), 0);
    check("R9", "bestValid", longint'(bestValid), 0);
    check("R9", "bestShift", longint'(bestShift), 0);
    rstN = 1'b1;

    // Vector table: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      buildVec(VEC[v]);
      writeSlot(v % DEPTH, eG, eGm);
      model(int'(VEC[v][15:0]));
      launch(v % DEPTH, int'(VEC[v][15:0]), 1'b0, lat);
      check("R6", $sformatf("vec%0d latency", v), lat, LAT);
      check("R6", $sformatf("vec%0d busy low at done", v), longint'(busy), 0);
      checkResult($sformatf("vec%0d", v));
      @(negedge clk);
      check("R6", $sformatf("vec%0d done one cycle", v), longint'(done), 0);
    end

    // R7: start while busy ignored, results held afterwards
    buildVec({4'd0, 8'sd1, 4'd12, 16'h4000});
    writeSlot(1, eG, eGm);
    model(16'h4000);
    launch(1, 16'h4000, 1'b1, lat);
    check("R7", "intruding start latency", lat, LAT);
    checkResult("R7 intrude");
    repeat (5) @(negedge clk);
    check("R7", "idle busy", longint'(busy), 0);
    checkResult("R7 hold");

    // R8: slot selection; other slots keep contents
    buildVec(VEC[9]);
    writeSlot(2, eG, eGm);
    buildVec(VEC[7]);
    writeSlot(3, eG, eGm);
    model(16'h4000);
    launch(3, 16'h4000, 1'b0, lat);
    checkResult("R8 slot3");
    buildVec(VEC[9]);
    model(1);
    launch(2, 1, 1'b0, lat);
    checkResult("R8 slot2");
    check("R3", "tie keeps lowest k", longint'(bestShift), -S);

    // R4: all-zero overlap reports zeros
    buildVec(VEC[10]);
    writeSlot(0, eG, eGm);
    launch(0, 16'hFFFF, 1'b0, lat);
    check("R4", "no overlap valid", longint'(bestValid), 0);
    check("R4", "no overlap shift", longint'(bestShift), 0);
    check("R4", "no overlap match", longint'(isMatch), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule